// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns parallel stereo sample pairs into a three-wire serial audio stream: a bit clock, a left/right frame clock and one data line. It derives the bit clock from its own clock (one bit period is two clock cycles) and counts bit periods to build frames of two 32-bit half-frames. A producer offers a left and a right sample word through a valid/ready handshake. The block starts the accepted pair at the next frame boundary. If no new pair has arrived by then, it sends the previous pair again.

Four framing modes can be chosen at run time: I2S, left-justified, right-justified with a selectable word width, and a DSP-style mode with a single-bit frame pulse. The mode and width inputs are sampled only at frame boundaries, so a frame that is already under way never changes. After reset the data line stays silent for a fixed number of frames while downstream logic settles. Samples are not accepted until that interval is nearly over.

Top module: `aud_serial_tx`

## Requirements
- R1: While reset is asserted, bclk, lrclk, sdata and in_ready are all low.
- R2: bclk toggles on every clock cycle (high and low for one cycle each). lrclk and sdata change only in the cycle where bclk falls. The first falling bclk edge after reset starts frame position 0, and a frame spans 64 bit periods (positions 0 to 63; positions 0 to 31 are the first half-frame, 32 to 63 the second).
- R3: sdata stays low for the first 20 frames after reset (frames 0 to 19). in_ready stays low until frame 19 begins, so a pair accepted during frame 19 is the first to be heard, in frame 20.
- R4: Mode code 000 (the value after reset) is I2S. lrclk is low for the left half-frame and high for the right half-frame. Each 24-bit word is sent MSB first starting at slot position 1 (positions 1 to 24 of its half). All other slot positions carry zero.
- R5: Mode code 011 is left-justified. lrclk is high for the left half-frame. The word is sent MSB first at slot positions 0 to 23, followed by zeros.
- R6: Mode code 001 is right-justified. lrclk is high for the left half-frame. Width code 00 sends 24 bits, 01 sends 20 and 10 sends 16; 11 is reserved and sends 24. The upper W bits of the sample are sent MSB first so that the last bit falls on slot position 31. Earlier slot positions carry zero.
- R7: Mode code 010 is DSP style. lrclk is high only at frame position 0. The left word is sent MSB first at positions 0 to 23 and the right word at positions 24 to 47. Positions 48 to 63 carry zero.
- R8: Mode codes 100 to 111 behave like I2S.
- R9: The mode and width inputs are sampled once, at the start of each frame. A change made in the middle of a frame leaves the rest of that frame unchanged and applies from the next frame.
- R10: A pair accepted (in_valid and in_ready high on a clock edge) during frame N is sent in frame N+1. After an acceptance, in_ready is low until the next frame starts.
- R11: If no pair was accepted during a frame, the next frame sends the previous pair again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bit clock runs at half its rate |
| rst | input | 1 | Synchronous reset, active high |
| fmt_mode | input | 3 | Framing mode code, sampled at each frame start |
| rj_width | input | 2 | Right-justified word width code, sampled at each frame start |
| in_valid | input | 1 | A sample pair is offered |
| in_ready | output | 1 | The block can accept a sample pair |
| in_left | input | 24 | Left sample word |
| in_right | input | 24 | Right sample word |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Left/right frame clock, or the frame pulse in DSP mode |
| sdata | output | 1 | Serial data, changing on falling bclk |

## Verification
The bound checker watches the properties that hold on every cycle. It confirms that the bit clock alternates, and that the data and frame clock move only when bclk falls. It checks that the data line is silent and in_ready is low through the initial frame window, using a count of falling edges. It also checks that in_ready drops right after every acceptance. Where each bit lands in a frame for each mode and width, the timing of a mid-frame configuration change, the one-frame delay from acceptance to playout, and the repetition of an old pair can only be shown by the bench's directed scenarios. The bench rebuilds whole frames and compares them with frames it computes from the requirements.

// File: rtl/ast_pkg.sv
`timescale 1ns/1ps
package ast_pkg;
   localparam logic [2:0] FMT_I2S = 3'b000;
   localparam logic [2:0] FMT_RJ  = 3'b001;
   localparam logic [2:0] FMT_DSP = 3'b010;
   localparam logic [2:0] FMT_LJ  = 3'b011;

   localparam logic [1:0] RJW_FULL = 2'b00;
   localparam logic [1:0] RJW_M4   = 2'b01;
   localparam logic [1:0] RJW_M8   = 2'b10;

   typedef struct packed {
      logic [2:0] mode;
      logic [1:0] wsel;
   } fmt_cfg_t;
endpackage

// File: rtl/ast_frame_timer.sv
`timescale 1ns/1ps
// Bit clock phase, frame position and the start-up mute window.
module ast_frame_timer #(
   parameter int SLOT_W      = 32,
   parameter int INIT_FRAMES = 20,
   localparam int POS_W      = $clog2(2 * SLOT_W),
   localparam int INIT_W     = $clog2(INIT_FRAMES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   output logic             bclk,
   output logic             upd,
   output logic             frame_start,
   output logic [POS_W-1:0] pos_nxt,
   output logic             mute_nxt,
   output logic             init_done
);
   localparam logic [POS_W-1:0]  POS_LAST = POS_W'(2 * SLOT_W - 1);
   localparam logic [INIT_W-1:0] INIT_END = INIT_W'(INIT_FRAMES);

   logic [POS_W-1:0]  pos;
   logic [INIT_W-1:0] init_cnt;
   logic              mute;

   // the edge that drops bclk is the edge that advances the line
   assign upd         = bclk;
   assign pos_nxt     = (pos == POS_LAST) ? '0 : pos + POS_W'(1);
   assign frame_start = upd && (pos == POS_LAST);
   assign init_done   = (init_cnt == INIT_END);
   assign mute_nxt    = frame_start ? !init_done : mute;

   always_ff @(posedge clk) begin
      if (rst) begin
         bclk     <= 1'b0;
         pos      <= POS_LAST;
         init_cnt <= '0;
         mute     <= 1'b1;
      end else begin
         bclk <= !bclk;
         if (upd) pos <= pos_nxt;
         if (frame_start) begin
            mute <= !init_done;
            if (!init_done) init_cnt <= init_cnt + INIT_W'(1);
         end
      end
   end
endmodule

// File: rtl/ast_pair_buf.sv
`timescale 1ns/1ps
// One-deep holding stage plus the pair currently on the line.
module ast_pair_buf #(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  logic                accept_en,
   input  logic                load,
   output logic                in_ready,
   output logic [SAMPLE_W-1:0] nxt_l,
   output logic [SAMPLE_W-1:0] nxt_r
);
   logic                pend_full;
   logic [SAMPLE_W-1:0] pend_l, pend_r, act_l, act_r;
   logic                take;

   assign in_ready = accept_en && !pend_full;
   assign take     = load && pend_full;
   assign nxt_l    = take ? pend_l : act_l;
   assign nxt_r    = take ? pend_r : act_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_full <= 1'b0;
         pend_l    <= '0;
         pend_r    <= '0;
         act_l     <= '0;
         act_r     <= '0;
      end else begin
         if (load) begin
            act_l <= nxt_l;
            act_r <= nxt_r;
         end
         if (in_valid && in_ready) begin
            pend_l    <= in_left;
            pend_r    <= in_right;
            pend_full <= 1'b1;
         end else if (take) begin
            pend_full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ast_bit_mux.sv
`timescale 1ns/1ps
// Chooses the frame clock level and data bit for one frame position.
module ast_bit_mux
   import ast_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int SLOT_W   = 32,
   localparam int POS_W   = $clog2(2 * SLOT_W)
) (
   input  fmt_cfg_t            cfg,
   input  logic [SAMPLE_W-1:0] left,
   input  logic [SAMPLE_W-1:0] right,
   input  logic [POS_W-1:0]    pos,
   output logic                lr,
   output logic                d
);
   function automatic logic pick(input logic [SAMPLE_W-1:0] v, input int i);
      logic [SAMPLE_W-1:0] t;
      t = v >> i;
      return t[0];
   endfunction

   int                  p, s, w, start;
   logic                half;
   logic [SAMPLE_W-1:0] word;

   always_comb begin
      p    = int'(pos);
      half = (p >= SLOT_W);
      s    = half ? p - SLOT_W : p;
      word = half ? right : left;
      case (cfg.wsel)
         RJW_M4:  w = SAMPLE_W - 4;
         RJW_M8:  w = SAMPLE_W - 8;
         default: w = SAMPLE_W;
      endcase
      start = SLOT_W - w;
      lr    = 1'b0;
      d     = 1'b0;
      case (cfg.mode)
         FMT_LJ: begin
            lr = !half;
            if (s < SAMPLE_W) d = pick(word, SAMPLE_W - 1 - s);
         end
         FMT_RJ: begin
            lr = !half;
            if (s >= start) d = pick(word, SAMPLE_W - 1 - (s - start));
         end
         FMT_DSP: begin
            lr = (p == 0);
            if (p < SAMPLE_W)          d = pick(left, SAMPLE_W - 1 - p);
            else if (p < 2 * SAMPLE_W) d = pick(right, 2 * SAMPLE_W - 1 - p);
         end
         default: begin
            lr = half;
            if (s >= 1 && s <= SAMPLE_W) d = pick(word, SAMPLE_W - s);
         end
      endcase
   end
endmodule

// File: rtl/aud_serial_tx.sv
`timescale 1ns/1ps
module aud_serial_tx
   import ast_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int SLOT_W      = 32,
   parameter int INIT_FRAMES = 20,
   localparam int POS_W      = $clog2(2 * SLOT_W)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [2:0]          fmt_mode,
   input  logic [1:0]          rj_width,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic                bclk,
   output logic                lrclk,
   output logic                sdata
);
   if (SAMPLE_W < 16 || SAMPLE_W > SLOT_W) begin : g_bad_width
      $error("aud_serial_tx: SAMPLE_W must lie in 16..SLOT_W");
   end
   if (INIT_FRAMES < 1) begin : g_bad_init
      $error("aud_serial_tx: INIT_FRAMES must be at least 1");
   end

   logic                upd, frame_start, mute_nxt, init_done;
   logic [POS_W-1:0]    pos_nxt;
   logic [SAMPLE_W-1:0] nxt_l, nxt_r;
   logic                lr_n, d_n;
   fmt_cfg_t            cfg, cfg_nxt;

   assign cfg_nxt = frame_start ? fmt_cfg_t'{mode: fmt_mode, wsel: rj_width} : cfg;

   ast_frame_timer #(.SLOT_W(SLOT_W), .INIT_FRAMES(INIT_FRAMES)) u_timer (
      .clk(clk), .rst(rst), .bclk(bclk), .upd(upd), .frame_start(frame_start),
      .pos_nxt(pos_nxt), .mute_nxt(mute_nxt), .init_done(init_done)
   );

   ast_pair_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
      .in_right(in_right), .accept_en(init_done), .load(frame_start),
      .in_ready(in_ready), .nxt_l(nxt_l), .nxt_r(nxt_r)
   );

   ast_bit_mux #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_mux (
      .cfg(cfg_nxt), .left(nxt_l), .right(nxt_r), .pos(pos_nxt),
      .lr(lr_n), .d(d_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg   <= '0;
         lrclk <= 1'b0;
         sdata <= 1'b0;
      end else if (upd) begin
         cfg   <= cfg_nxt;
         lrclk <= lr_n;
         sdata <= d_n && !mute_nxt;
      end
   end
endmodule

// File: rtl/ast_tx_chk.sv
`timescale 1ns/1ps
module ast_tx_chk #(
   parameter int SLOT_W      = 32,
   parameter int INIT_FRAMES = 20,
   localparam int FRAME_BITS = 2 * SLOT_W,
   localparam int MUTE_END   = INIT_FRAMES * FRAME_BITS,
   localparam int READY_AT   = (INIT_FRAMES - 1) * FRAME_BITS + 1,
   localparam int CNT_W      = $clog2(MUTE_END + 2)
) (
   input logic clk,
   input logic rst,
   input logic bclk,
   input logic lrclk,
   input logic sdata,
   input logic in_valid,
   input logic in_ready
);
   logic             past_ok;
   logic [CNT_W-1:0] fcnt;

   // fcnt counts falling bclk edges, saturating once past the mute window
   always_ff @(posedge clk) begin
      if (rst) begin
         past_ok <= 1'b0;
         fcnt    <= '0;
      end else begin
         past_ok <= 1'b1;
         if (bclk && int'(fcnt) <= MUTE_END) fcnt <= fcnt + CNT_W'(1);
      end
   end

   // R2
   bclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      past_ok |-> (bclk != $past(bclk)));
   // R2
   sdata_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$stable(sdata)) |-> $fell(bclk));
   // R2
   lrclk_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$stable(lrclk)) |-> $fell(bclk));
   // R3
   init_mute_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(fcnt) <= MUTE_END) |-> !sdata);
   // R3
   init_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(fcnt) < READY_AT) |-> !in_ready);
   // R10
   one_deep_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);
endmodule

bind aud_serial_tx ast_tx_chk #(.SLOT_W(SLOT_W), .INIT_FRAMES(INIT_FRAMES)) u_chk (
   .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
   .in_valid(in_valid), .in_ready(in_ready)
);

// File: tb/aud_serial_tx_test.sv
`timescale 1ns/1ps
module aud_serial_tx_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  fmt_mode = 3'b000;
   logic [1:0]  rj_width = 2'b00;
   logic        in_valid = 1'b0;
   logic [23:0] in_left = '0, in_right = '0;
   logic        in_ready, bclk, lrclk, sdata;

   always #2.5 clk = ~clk;

   aud_serial_tx uut (
      .clk(clk), .rst(rst), .fmt_mode(fmt_mode), .rj_width(rj_width),
      .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
      .in_right(in_right), .bclk(bclk), .lrclk(lrclk), .sdata(sdata)
   );

   int checks = 0, fails = 0;

   // frame monitor: rebuilds each frame from bits seen at rising bclk
   int          bpos = 62;
   bit          have0 = 1'b0;
   int          frames_done = 0;
   logic [63:0] cur_sd = '0, cur_lr = '0, last_sd = '0, last_lr = '0;
   int          init_sd_viol = 0, init_rdy_viol = 0, edge_viol = 0;
   logic        prev_bclk = 1'b0, prev_sd = 1'b0, prev_lr = 1'b0;

   always @(negedge clk) begin
      if (!rst) begin
         if ((sdata != prev_sd || lrclk != prev_lr) && !(prev_bclk && !bclk))
            edge_viol++;
         if (bclk && !prev_bclk) begin
            bpos = (bpos == 63) ? 0 : bpos + 1;
            if (bpos == 0) have0 = 1'b1;
            if (have0) begin
               cur_sd[bpos] = sdata;
               cur_lr[bpos] = lrclk;
               if (frames_done < 20 && sdata) init_sd_viol++;
               if (bpos == 63) begin
                  last_sd = cur_sd;
                  last_lr = cur_lr;
                  frames_done++;
               end
            end
         end
         if (frames_done < 19 && in_ready) init_rdy_viol++;
      end
      prev_bclk = bclk;
      prev_sd   = sdata;
      prev_lr   = lrclk;
   end

   // expected {lrclk, sdata} at frame position p, from the requirements
   function automatic logic [1:0] exp_bit(logic [2:0] m, logic [1:0] w,
                                          logic [23:0] L, logic [23:0] R, int p);
      int          s, wid;
      bit          rh;
      logic [23:0] wd;
      logic        lr, d;
      s   = p % 32;
      rh  = (p >= 32);
      wd  = rh ? R : L;
      wid = (w == 2'b01) ? 20 : (w == 2'b10) ? 16 : 24;
      lr  = 1'b0;
      d   = 1'b0;
      if (m == 3'b011) begin
         lr = !rh;
         if (s < 24) d = wd[23 - s];
      end else if (m == 3'b001) begin
         lr = !rh;
         if (s >= 32 - wid) d = wd[23 - (s - (32 - wid))];
      end else if (m == 3'b010) begin
         lr = (p == 0);
         if (p < 24) d = L[23 - p];
         else if (p < 48) d = R[47 - p];
      end else begin
         lr = rh;
         if (s >= 1 && s <= 24) d = wd[24 - s];
      end
      return {lr, d};
   endfunction

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_frame(string req, logic [2:0] m, logic [1:0] w,
                              logic [23:0] L, logic [23:0] R);
      logic [63:0] esd, elr;
      logic [1:0]  b;
      for (int p = 0; p < 64; p++) begin
         b = exp_bit(m, w, L, R, p);
         elr[p] = b[1];
         esd[p] = b[0];
      end
      check(last_sd == esd, req, "frame data", last_sd, esd);
      check(last_lr == elr, req, "frame clock", last_lr, elr);
   endtask

   task automatic wait_frames(int n);
      while (frames_done < n) @(negedge clk);
   endtask

   task automatic wait_mid();
      @(negedge clk);
      while (!(have0 && bpos >= 8 && bpos <= 40)) @(negedge clk);
   endtask

   task automatic push(logic [23:0] L, logic [23:0] R);
      in_left  = L;
      in_right = R;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   logic [2:0]  cm = 3'b000;
   logic [1:0]  cw = 2'b00;
   logic [23:0] cL = '0, cR = '0;

   // set the format and offer a pair mid-frame, then check both frames
   task automatic run_case(string req, logic [2:0] m, logic [1:0] w,
                           logic [23:0] L, logic [23:0] R);
      int f;
      wait_mid();
      f = frames_done;
      fmt_mode = m;
      rj_width = w;
      push(L, R);
      check(in_ready == 1'b0, "R10", "ready after accept", {63'd0, in_ready}, 64'd0);
      wait_frames(f + 1);
      check_frame("R9", cm, cw, cL, cR);
      wait_frames(f + 2);
      check_frame(req, m, w, L, R);
      cm = m; cw = w; cL = L; cR = R;
   endtask

   task automatic t_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      check({bclk, lrclk, sdata, in_ready} == 4'b0000, "R1", "outputs in reset",
            {60'd0, bclk, lrclk, sdata, in_ready}, 64'd0);
      rst = 1'b0;
   endtask

   task automatic t_clock();
      logic a, b;
      @(negedge clk); a = bclk;
      @(negedge clk); b = bclk;
      check(a != b, "R2", "bclk toggles", {62'd0, a, b}, {62'd0, a, !a});
   endtask

   task automatic t_init();
      wait_frames(19);
      check(init_rdy_viol == 0, "R3", "ready low before frame 19",
            64'(init_rdy_viol), 64'd0);
      wait_mid();
      check(in_ready == 1'b1, "R3", "ready in frame 19", {63'd0, in_ready}, 64'd1);
      run_case("R4", 3'b000, 2'b00, 24'hA5C3F1, 24'h5E1B27);
      check(init_sd_viol == 0, "R3", "silent first 20 frames", 64'(init_sd_viol), 64'd0);
   endtask

   task automatic t_repeat();
      int f;
      f = frames_done;
      wait_frames(f + 1);
      check_frame("R11", cm, cw, cL, cR);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_clock();
      t_init();
      t_repeat();
      run_case("R5", 3'b011, 2'b00, 24'h8F0E35, 24'h71B2C9);
      run_case("R6", 3'b001, 2'b00, 24'hC3A597, 24'h2D4E61);
      run_case("R6", 3'b001, 2'b01, 24'h9B7F13, 24'h64C8AD);
      run_case("R6", 3'b001, 2'b10, 24'hE6152B, 24'h1A9F77);
      run_case("R6", 3'b001, 2'b11, 24'h4B3D8F, 24'hB0C5E3);
      run_case("R7", 3'b010, 2'b00, 24'hD2716B, 24'h3F8A05);
      t_repeat();
      run_case("R8", 3'b101, 2'b10, 24'h7C2E99, 24'h85D347);
      run_case("R8", 3'b111, 2'b00, 24'h16B5E1, 24'hF94A3D);
      run_case("R4", 3'b000, 2'b00, 24'h800001, 24'h7FFFFF);
      check(edge_viol == 0, "R2", "changes only on falling bclk", 64'(edge_viol), 64'd0);
      finish_run();
   end
endmodule